// File: doc/BRIEF.md
# Two-wire serial EEPROM target

This block is the target side of a two-wire serial bus. It fronts a 128-byte storage array held in registers. A fast system clock samples the clock line (SCL) and the data line (SDA). The block drives SDA as an open-drain output: when `sda_pull_o` is high, the line is pulled low. The block finds start and stop conditions, shifts bytes in and out, and answers with acknowledge bits. It supports single-byte writes, 4-byte page writes, single-byte reads and sequential reads.

A transfer opens with a start condition. The first byte that follows carries a 7-bit word address and a direction bit. There is no separate device-select byte. Written bytes are held in a small page buffer and reach the array only at the stop condition that closes the write. The array then runs a timed write cycle of `WR_CYCLES` system clocks. During that cycle the block does not touch the bus, so a host can repeat the address byte until it is acknowledged.

The system clock must run at least 8 times faster than SCL.

Top module: `twi_ee_target`

## Requirements
- R1: After reset, `sda_pull_o` is low (the line is released) and every array byte reads as 0x00.
- R2: A start condition is SDA falling while SCL is high, and a stop condition is SDA rising while SCL is high. The first byte after a start is sent MSB first. Its bits 7..1 are the word address and its bit 0 is the direction (0 = write, 1 = read). The block acknowledges that byte by holding SDA low through the ninth clock.
- R3: In a write, each data byte is acknowledged in its ninth clock. After the closing stop and the write cycle, the byte reads back from its word address.
- R4: Within a write, only address bits 1..0 advance after each data byte, and bits 6..2 keep the page. A fifth or later byte wraps to the start of the same 4-byte page and overwrites the byte stored there.
- R5: Only page positions that actually received a byte in the write are updated. The other bytes of the page keep their old contents.
- R6: A write cycle starts only at a stop that ends a write in which at least one full data byte was received. A write stopped right after its address byte starts no write cycle. Bytes staged before a repeated start are discarded.
- R7: The write cycle lasts exactly `WR_CYCLES` system clocks. During it the block never pulls SDA, acknowledges nothing, and ignores any command on the bus.
- R8: In a read, the block sends the byte at the current word address, MSB first. It changes SDA only while SCL is low.
- R9: When the host acknowledges a read byte, the full 7-bit address advances, wrapping from 127 to 0, and the next byte follows.
- R10: When the host does not acknowledge a read byte, the block leaves SDA released from then on and drives nothing until the next start.
- R11: A start condition in the middle of any transfer aborts that transfer and begins a new address byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus (wired-AND) |
| sda_pull_o | output | 1 | High pulls SDA low; low releases it |

## Verification
The checker watches the following on every cycle:
- the line is never pulled during the write cycle;
- a pull is started or released only while the synchronised SCL is low;
- every write cycle is opened by a stop condition and lasts exactly `WR_CYCLES` clocks;
- a start condition outside the write cycle always leads to a fresh address phase.

Only the bench's scenarios can show what lands in the array. That covers page wrap and overwrite, partial pages, bytes discarded on a repeated start, commands ignored while busy, and read data order with the 127-to-0 wrap. A scoreboard compares each of these against values the bench predicts from the requirements.

// File: rtl/twi_ee_pkg.sv
package twi_ee_pkg;
  localparam int unsigned WORD_W = 8;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned LANE_W = 2;
  localparam int unsigned LANES  = 1 << LANE_W;
  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned ROW_W  = ADDR_W - LANE_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] waddr_t;
  typedef logic [LANE_W-1:0] lane_t;
  typedef logic [ROW_W-1:0]  row_t;
  typedef logic [LANES-1:0][WORD_W-1:0] stage_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RECV, PH_ACK, PH_SEND, PH_HACK
  } phase_e;

  // write pointer: advance inside the current page only
  function automatic waddr_t page_step(waddr_t a);
    lane_t l;
    l = a[LANE_W-1:0] + lane_t'(1);
    return {a[ADDR_W-1:LANE_W], l};
  endfunction

  // read pointer: advance over the whole array with natural wrap
  function automatic waddr_t seq_step(waddr_t a);
    return a + waddr_t'(1);
  endfunction
endpackage

// File: rtl/twi_ee_linesync.sv
module twi_ee_linesync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_p  <= scl_sh[STAGES-1];
      sda_p  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/twi_ee_wtimer.sv
module twi_ee_wtimer #(
  parameter int unsigned WR_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic busy
);
  localparam int unsigned CNT_W = $clog2(WR_CYCLES + 1);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (launch)         remain <= CNT_W'(WR_CYCLES);
    else if (remain != '0)   remain <= remain - CNT_W'(1);
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/twi_ee_array.sv
module twi_ee_array
  import twi_ee_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     commit,
  input  row_t     row,
  input  stage_t   stage_data,
  input  logic [LANES-1:0] stage_vld,
  input  waddr_t   rd_addr,
  output word_t    rd_data
);
  word_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit) begin
      for (int l = 0; l < LANES; l++)
        if (stage_vld[l]) mem[{row, lane_t'(l)}] <= stage_data[l];
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/twi_ee_engine.sv
module twi_ee_engine
  import twi_ee_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   busy,
  input  logic   sda_s,
  input  logic   scl_rise,
  input  logic   scl_fall,
  input  logic   start_det,
  input  logic   stop_det,
  input  word_t  rd_data,
  output waddr_t rd_addr,
  output row_t   row,
  output stage_t stage_data,
  output logic [LANES-1:0] stage_vld,
  output logic   commit,
  output logic   addr_phase,
  output logic   sda_pull
);
  phase_e     phase;
  logic [3:0] bitcnt;
  word_t      shreg, txsh;
  logic       is_addr, rw, hack;
  waddr_t     addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      bitcnt     <= '0;
      shreg      <= '0;
      txsh       <= '0;
      is_addr    <= 1'b0;
      rw         <= 1'b0;
      hack       <= 1'b0;
      addr       <= '0;
      stage_data <= '0;
      stage_vld  <= '0;
    end else if (busy) begin
      phase     <= PH_IDLE;
      stage_vld <= '0;
    end else if (start_det) begin
      phase     <= PH_RECV;
      bitcnt    <= '0;
      is_addr   <= 1'b1;
      stage_vld <= '0;
    end else if (stop_det) begin
      phase     <= PH_IDLE;
      stage_vld <= '0;
    end else begin
      unique case (phase)
        PH_RECV: begin
          if (scl_rise && bitcnt != 4'd8) begin
            shreg  <= {shreg[WORD_W-2:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            phase <= PH_ACK;
            if (is_addr) begin
              addr <= shreg[WORD_W-1:1];
              rw   <= shreg[0];
            end else begin
              stage_data[addr[LANE_W-1:0]] <= shreg;
              stage_vld[addr[LANE_W-1:0]]  <= 1'b1;
              addr <= page_step(addr);
            end
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            bitcnt  <= '0;
            is_addr <= 1'b0;
            if (rw) begin
              phase <= PH_SEND;
              txsh  <= rd_data;
            end else begin
              phase <= PH_RECV;
            end
          end
        end
        PH_SEND: begin
          if (scl_fall) begin
            txsh <= {txsh[WORD_W-2:0], 1'b0};
            if (bitcnt == 4'd7) begin
              phase  <= PH_HACK;
              bitcnt <= '0;
            end else begin
              bitcnt <= bitcnt + 4'd1;
            end
          end
        end
        PH_HACK: begin
          if (scl_rise) begin
            hack <= ~sda_s;
          end else if (scl_fall) begin
            if (hack) begin
              addr  <= seq_step(addr);
              txsh  <= rd_data;
              phase <= PH_SEND;
            end else begin
              phase <= PH_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign rd_addr    = (phase == PH_HACK) ? seq_step(addr) : addr;
  assign row        = addr[ADDR_W-1:LANE_W];
  assign commit     = stop_det & ~busy & (|stage_vld);
  assign addr_phase = (phase == PH_RECV) & is_addr;
  assign sda_pull   = (phase == PH_ACK) | ((phase == PH_SEND) & ~txsh[WORD_W-1]);
endmodule

// File: rtl/twi_ee_target.sv
module twi_ee_target
  import twi_ee_pkg::*;
#(
  parameter int unsigned WR_CYCLES   = 250000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o
);
  logic   scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic   busy, commit, addr_phase;
  waddr_t rd_addr;
  word_t  rd_data;
  row_t   row;
  stage_t stage_data;
  logic [LANES-1:0] stage_vld;

  twi_ee_linesync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst_n, .scl_i, .sda_i,
    .scl_s, .sda_s, .scl_rise, .scl_fall, .start_det, .stop_det
  );

  twi_ee_engine u_eng (
    .clk, .rst_n, .busy, .sda_s, .scl_rise, .scl_fall, .start_det, .stop_det,
    .rd_data, .rd_addr, .row, .stage_data, .stage_vld, .commit, .addr_phase,
    .sda_pull(sda_pull_o)
  );

  twi_ee_wtimer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
    .clk, .rst_n, .launch(commit), .busy
  );

  twi_ee_array u_arr (
    .clk, .rst_n, .commit, .row, .stage_data, .stage_vld, .rd_addr, .rd_data
  );
endmodule

// File: rtl/twi_ee_checker.sv
module twi_ee_checker #(
  parameter int unsigned WR_CYCLES = 250000
) (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_pull,
  input logic busy,
  input logic commit,
  input logic start_det,
  input logic stop_det,
  input logic addr_phase
);
  int unsigned run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  assert_silent_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pull);

  assert_busy_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_len == WR_CYCLES);

  assert_pull_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_s);

  assert_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> busy);

  assert_busy_from_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det));

  assert_new_addr_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !busy) |=> addr_phase);
endmodule

bind twi_ee_target twi_ee_checker #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_pull(sda_pull_o), .busy(busy),
  .commit(commit), .start_det(start_det), .stop_det(stop_det),
  .addr_phase(addr_phase)
);

// File: tb/twi_ee_target_tb.sv
module twi_ee_target_tb;
  localparam int WR = 600;
  localparam int Q  = 4;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, host_sda = 1'b1;
  logic sda_pull, sda_line;
  assign sda_line = host_sda & ~sda_pull;

  always #10 clk = ~clk;

  twi_ee_target #(.WR_CYCLES(WR)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_pull_o(sda_pull)
  );

  int n_chk = 0, n_bad = 0;
  typedef struct { logic [7:0] v; string tag; } exp_t;
  exp_t exp_q[$];
  logic [7:0] rd_val;
  event rd_done;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] v, input string tag);
    exp_t e;
    e.v = v; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // scoreboard monitor
  initial forever begin
    @(rd_done);
    if (exp_q.size() == 0) check(1'b0, "R8", rd_val, 0);
    else begin
      exp_t e;
      e = exp_q.pop_front();
      check(rd_val == e.v, e.tag, rd_val, e.v);
    end
  end

  task automatic q(); repeat (Q) @(negedge clk); endtask

  task automatic clk_bit(input logic b, output logic r);
    host_sda = b; q(); scl = 1'b1; q(); r = sda_line; q(); scl = 1'b0; q();
  endtask

  task automatic start_c();
    host_sda = 1'b1; q(); scl = 1'b1; q(); host_sda = 1'b0; q(); scl = 1'b0; q();
  endtask

  task automatic stop_c();
    host_sda = 1'b0; q(); scl = 1'b1; q(); host_sda = 1'b1; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
    clk_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic host_ack);
    logic r;
    logic [7:0] b;
    b = '0;
    for (int i = 0; i < 8; i++) begin clk_bit(1'b1, r); b = {b[6:0], r}; end
    clk_bit(~host_ack, r);
    if (!host_ack) check(r == 1'b1, "R10", r, 1);
    rd_val = b;
    -> rd_done;
  endtask

  task automatic write_bytes(input logic [6:0] a, input logic [7:0] d [8], input int n,
                             input string tag);
    logic ack;
    start_c();
    send_byte({a, 1'b0}, ack); check(ack, "R2", ack, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(d[k], ack); check(ack, tag, ack, 1);
    end
    stop_c();
  endtask

  task automatic read_seq(input logic [6:0] a, input int n);
    logic ack;
    start_c();
    send_byte({a, 1'b1}, ack); check(ack, "R2", ack, 1);
    for (int k = 0; k < n; k++) recv_byte(k != n - 1);
    stop_c();
  endtask

  task automatic wait_cycle(); repeat (WR + 20) @(negedge clk); endtask

  initial begin
    logic [7:0] d [8];
    logic ack, r;
    int nacks;
    bit got;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    q();
    check(sda_pull == 1'b0, "R1", sda_pull, 0);
    push(8'h00, "R1"); read_seq(7'h05, 1);

    // R3 byte write, then R7 ignored command and ack polling
    d[0] = 8'hA1; write_bytes(7'h10, d, 1, "R3");
    start_c(); send_byte({7'h60, 1'b0}, ack); check(!ack, "R7", ack, 0);
    send_byte(8'h11, ack); check(!ack, "R7", ack, 0); stop_c();
    nacks = 0; got = 0;
    for (int p = 0; p < 20 && !got; p++) begin
      start_c(); send_byte({7'h10, 1'b1}, ack);
      if (ack) begin push(8'hA1, "R3"); recv_byte(1'b0); got = 1; end
      else nacks++;
      stop_c();
    end
    check(got && nacks >= 1, "R7", nacks, 1);
    push(8'h00, "R7"); read_seq(7'h60, 1);

    // R4 page write with wrap and overwrite
    for (int k = 0; k < 6; k++) d[k] = 8'hD0 + 8'(k);
    write_bytes(7'h22, d, 6, "R4"); wait_cycle();
    push(8'hD2, "R4"); push(8'hD3, "R4"); push(8'hD4, "R4"); push(8'hD5, "R4");
    push(8'h00, "R4"); read_seq(7'h20, 5);

    // R5 partial page
    d[0] = 8'hE0; d[1] = 8'hE1; write_bytes(7'h31, d, 2, "R5"); wait_cycle();
    push(8'h00, "R5"); push(8'hE0, "R5"); push(8'hE1, "R5"); push(8'h00, "R5");
    read_seq(7'h30, 4);

    // R9 sequential wrap 127 -> 0
    d[0] = 8'h5A; write_bytes(7'h7F, d, 1, "R3"); wait_cycle();
    d[0] = 8'hC3; write_bytes(7'h00, d, 1, "R3"); wait_cycle();
    push(8'h00, "R9"); push(8'h5A, "R9"); push(8'hC3, "R9"); read_seq(7'h7E, 3);

    // R8 MSB-first order
    d[0] = 8'h96; write_bytes(7'h0C, d, 1, "R3"); wait_cycle();
    push(8'h96, "R8"); read_seq(7'h0C, 1);

    // R6 address-only write starts no cycle
    start_c(); send_byte({7'h40, 1'b0}, ack); check(ack, "R2", ack, 1); stop_c();
    start_c(); send_byte({7'h40, 1'b1}, ack); check(ack, "R6", ack, 1);
    push(8'h00, "R6"); recv_byte(1'b0); stop_c();

    // R11 repeated start after a full byte: staged data discarded (R6)
    start_c(); send_byte({7'h50, 1'b0}, ack); send_byte(8'h77, ack);
    start_c(); send_byte({7'h50, 1'b1}, ack); check(ack, "R11", ack, 1);
    push(8'h00, "R6"); recv_byte(1'b0); stop_c();
    // R11 start inside a data byte
    start_c(); send_byte({7'h58, 1'b0}, ack);
    for (int i = 0; i < 3; i++) clk_bit(1'b0, r);
    start_c(); send_byte({7'h58, 1'b1}, ack); check(ack, "R11", ack, 1);
    push(8'h00, "R11"); recv_byte(1'b0); stop_c();

    // R10 released after nack and stop; next access works
    q();
    check(sda_pull == 1'b0, "R10", sda_pull, 0);
    push(8'h96, "R10"); read_seq(7'h0C, 1);

    q();
    check(exp_q.size() == 0, "R8", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R7: watchdog expired got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule